// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked host read and write an asynchronous static RAM array of 131072 words by 32 bits. The array is built from four byte-wide devices. Each device has its own active-low select. The devices share one write strobe, one output-enable strobe and a 17-bit address. The host issues a one-cycle request that carries the address, the write data, a 4-bit lane mask and a direction flag. The controller then runs the strobes through a fixed sequence whose phase lengths, in clock cycles, come from parameters. When the access completes, it pulses a ready output for one cycle.

A device stores data only while its select and the write strobe are both low. The strobe order is therefore fixed. The selects fall before the write strobe falls, and the write strobe rises before the selects rise, so the data and the address are steady at the edge that ends the write. The controller drives the shared data bus only during writes. During reads it releases the bus, registers the returned word and forces the lanes outside the mask to zero.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is asserted and while idle, all four selects, the write strobe and the output enable are high, the data bus is released, and ready is low.
- R2: In a write, the selects go low one cycle before the write strobe falls. The write strobe stays low for exactly T_PWE_CYC cycles, then rises one cycle before the selects rise.
- R3: Mask bit i controls select i, which covers data bits 8i+7:8i. Only lanes whose mask bit is 1 have their select driven low during an access.
- R4: The bus-drive output is high with the write data on the bus from the first write cycle through the cycle in which the selects rise. It is low during reads and idle cycles.
- R5: The SRAM address equals the accepted request address during every cycle in which any select is low.
- R6: In a read, the selected lanes and the output enable stay low for T_ACC_CYC cycles. The bus is then registered, and the read data shows the selected lanes with every masked-off lane reading zero.
- R7: Ready is high for exactly one cycle. For a write this is cycle T_PWE_CYC+3 after acceptance; for a read it is cycle T_ACC_CYC+1 after acceptance.
- R8: A request raised while an access is in progress is ignored. It causes no strobe activity and no memory change.
- R9: The write strobe is low only while the bus is driven and the output enable is high.
- R10: The write-strobe low time is at least 12 ns, and the read strobes are held at least 15 ns before capture. Parameter values that break these limits stop elaboration.
- R11: Asserting reset during an access returns all strobes to their inactive levels at once, releases the bus and drops the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request, taken only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 32 | Write data |
| mask_i | input | 4 | Lane mask, bit i = bits 8i+7:8i |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, masked lanes zero |
| sram_addr_o | output | 17 | SRAM address |
| sram_cs_no | output | 4 | Per-lane selects, active low |
| sram_we_no | output | 1 | Shared write strobe, active low |
| sram_oe_no | output | 1 | Shared output enable, active low |
| sram_dq_o | output | 32 | Data driven onto the bus |
| sram_dq_oe_o | output | 1 | Bus drive enable |
| sram_dq_i | input | 32 | Data read from the bus |

## Verification
The hardest situations to reach are a second request that lands in the middle of a write strobe and a reset that arrives while the write strobe is low. The bench raises a request with different address and data two cycles into a write. It then reads that second address back through the normal read path to show that nothing was stored there. Reset is applied at the falling edge inside the write pulse, and the strobes are sampled one nanosecond later. Lanes that are not selected return a nonzero pattern from the bench memory, so that a missing mask on the read path shows up at rdata_o.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_WDONE,
    ST_RACC,
    ST_RDONE
  } ctrl_state_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        mask_i,
  output logic [LANES-1:0]        cs_n_o,
  output logic [LANES*LANE_W-1:0] bits_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cs_n_o[l]                 = ~mask_i[l];
    assign bits_o[l*LANE_W +: LANE_W] = {LANE_W{mask_i[l]}};
  end
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int CLK_NS     = 20,
  parameter int T_PWE_CYC  = 2,
  parameter int T_SD_CYC   = 1,
  parameter int T_ACC_CYC  = 2,
  parameter int PWE_MIN_NS = 12,
  parameter int SD_MIN_NS  = 7,
  parameter int ACC_MAX_NS = 15,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  mask_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [LANES-1:0]  sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int MAX_CYC = (T_PWE_CYC > T_ACC_CYC) ? T_PWE_CYC : T_ACC_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  // elaboration guards on phase lengths
  if (T_PWE_CYC < 1 || T_PWE_CYC * CLK_NS < PWE_MIN_NS) begin : g_bad_pwe
    $error("write pulse too short");
  end
  if (T_SD_CYC < 1 || T_SD_CYC > T_PWE_CYC || T_SD_CYC * CLK_NS < SD_MIN_NS) begin : g_bad_sd
    $error("data setup too short");
  end
  if (T_ACC_CYC < 1 || T_ACC_CYC * CLK_NS < ACC_MAX_NS) begin : g_bad_acc
    $error("read access window too short");
  end

  ctrl_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  lane_cs_n;
  logic [DATA_W-1:0] lane_bits;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              take;

  assign take = (state_q == ST_IDLE) && req_i;

  sram_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lane_map (
    .mask_i (mask_q),
    .cs_n_o (lane_cs_n),
    .bits_o (lane_bits)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d  = we_i ? ST_WSETUP : ST_RACC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_ACC_CYC - 1);
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_PWE_CYC - 1);
      end
      ST_WPULSE: if (tmr_done) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_WDONE;
      ST_WDONE:  state_d = ST_IDLE;
      ST_RACC:   if (tmr_done) state_d = ST_RDONE;
      ST_RDONE:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        mask_q  <= mask_i;
      end
      if (state_q == ST_RACC && tmr_done) rdata_q <= sram_dq_i & lane_bits;
    end
  end

  logic sel_act;
  assign sel_act = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                   (state_q == ST_WHOLD)  || (state_q == ST_RACC);

  assign sram_cs_no   = sel_act ? lane_cs_n : '1;
  assign sram_we_no   = (state_q != ST_WPULSE);
  assign sram_oe_no   = (state_q != ST_RACC);
  assign sram_dq_oe_o = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                        (state_q == ST_WHOLD)  || (state_q == ST_WDONE);
  assign sram_dq_o    = wdata_q;
  assign sram_addr_o  = addr_q;
  assign ready_o      = (state_q == ST_WDONE) || (state_q == ST_RDONE);
  assign rdata_o      = rdata_q;
endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [LANES-1:0]  sram_cs_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_dq_oe_o
);
  assert_we_after_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $stable(sram_cs_no));

  assert_cs_after_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sram_we_no) && (sram_cs_no != '1)) |=> (sram_cs_no == '1));

  assert_write_has_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_dq_oe_o && sram_oe_no));

  assert_read_bus_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> !sram_dq_oe_o);

  assert_addr_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sram_cs_no != '1) && ($past(sram_cs_no) != '1)) |-> $stable(sram_addr_o));

  assert_ready_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .sram_addr_o  (sram_addr_o),
  .sram_cs_no   (sram_cs_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_byte_ctrl_bench.sv
module sram_byte_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_NS = 20;
  localparam int T_PWE  = 2;
  localparam int T_ACC  = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  mask = '0;
  logic        ready;
  logic [31:0] rdata, dq_o, dq_i, mem_word;
  logic [16:0] s_addr;
  logic [3:0]  cs_n;
  logic        we_n, oe_n, dq_oe;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] mem     [256];
  logic [31:0] exp_mem [256];

  always #(CLK_NS/2) clk = ~clk;

  sram_byte_ctrl #(.CLK_NS(CLK_NS), .T_PWE_CYC(T_PWE), .T_ACC_CYC(T_ACC)) u_sram_byte_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mask_i(mask), .ready_o(ready), .rdata_o(rdata),
    .sram_addr_o(s_addr), .sram_cs_no(cs_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // behavioural array: unselected lanes return a junk pattern
  assign mem_word = mem[s_addr[7:0]];
  for (genvar l = 0; l < 4; l++) begin : g_bus
    assign dq_i[l*8 +: 8] = (!oe_n && !cs_n[l] && we_n) ? mem_word[l*8 +: 8] : 8'hA5;
  end

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!cs_n[l] && !we_n && dq_oe) mem[s_addr[7:0]][l*8 +: 8] <= dq_o[l*8 +: 8];
  end

  function automatic logic [31:0] lane_bits(input logic [3:0] m);
    for (int l = 0; l < 4; l++) lane_bits[l*8 +: 8] = {8{m[l]}};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string tag);
    check(cs_n == 4'hF && we_n && oe_n && !dq_oe && !ready, tag,
          {24'h0, cs_n, we_n, oe_n, dq_oe, ready}, 32'h000000FC);
  endtask

  task automatic run(input bit wr, input logic [16:0] a, input logic [31:0] d,
                     input logic [3:0] m, input bit inject);
    int len, we_low, acc;
    logic [3:0] e_cs;
    logic e_we, e_oe, e_dq, e_rdy;
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; wdata = d; mask = m;
    @(negedge clk);
    req = 1'b0;
    len = wr ? T_PWE + 4 : T_ACC + 2;
    we_low = 0; acc = 0;
    for (int k = 1; k <= len; k++) begin
      e_cs = 4'hF; e_we = 1'b1; e_oe = 1'b1; e_dq = 1'b0; e_rdy = 1'b0;
      if (wr) begin
        if (k <= T_PWE + 2) e_cs = ~m;
        if (k >= 2 && k <= T_PWE + 1) e_we = 1'b0;
        if (k <= T_PWE + 3) e_dq = 1'b1;
        if (k == T_PWE + 3) e_rdy = 1'b1;
      end else begin
        if (k <= T_ACC) begin e_cs = ~m; e_oe = 1'b0; end
        if (k == T_ACC + 1) e_rdy = 1'b1;
      end
      check(cs_n == e_cs, "R3 lane selects", {28'h0, cs_n}, {28'h0, e_cs});
      check(we_n == e_we && oe_n == e_oe, wr ? "R2 write strobes" : "R6 read strobes",
            {30'h0, we_n, oe_n}, {30'h0, e_we, e_oe});
      check(dq_oe == e_dq, "R4 bus drive", {31'h0, dq_oe}, {31'h0, e_dq});
      check(ready == e_rdy, "R7 ready pulse", {31'h0, ready}, {31'h0, e_rdy});
      if (e_dq) check(dq_o == d, "R4 write data", dq_o, d);
      if (e_cs != 4'hF) check(s_addr == a, "R5 address", {15'h0, s_addr}, {15'h0, a});
      if (!we_n) begin
        we_low++;
        check(dq_oe && oe_n, "R9 write with data", {30'h0, dq_oe, oe_n}, 32'h3);
      end
      if (!oe_n) acc++;
      if (!wr && e_rdy) check(rdata == (exp_mem[a[7:0]] & lane_bits(m)), "R6 read data",
                              rdata, exp_mem[a[7:0]] & lane_bits(m));
      if (inject && k == 2) begin
        req = 1'b1; we = 1'b1; addr = a + 17'h10; wdata = 32'hDEADBEEF; mask = 4'hF;
      end
      if (inject && k == 3) req = 1'b0;
      if (k < len) @(negedge clk);
    end
    if (wr) begin
      check(we_low * CLK_NS >= 12 && we_low == T_PWE, "R10 write pulse width",
            we_low, T_PWE);
      for (int l = 0; l < 4; l++) if (m[l]) exp_mem[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    end else if (m != 4'h0) begin
      check(acc * CLK_NS >= 15, "R10 read access window", acc, T_ACC);
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    #3;
    check_idle("R1 reset state");
    repeat (3) @(negedge clk);
    check_idle("R1 reset held");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");

    run(1, 17'h00010, 32'h11223344, 4'hF, 0);
    run(0, 17'h00010, 32'h0,        4'hF, 0);
    run(1, 17'h00010, 32'hAABBCCDD, 4'h5, 0);
    run(0, 17'h00010, 32'h0,        4'hF, 0);
    run(0, 17'h00010, 32'h0,        4'h6, 0);
    run(1, 17'h1FFFF, 32'h5A000000, 4'h8, 0);
    run(0, 17'h1FFFF, 32'h0,        4'hF, 0);
    run(1, 17'h00020, 32'hCAFEF00D, 4'hF, 1);
    @(negedge clk);
    check_idle("R8 no access started by busy request");
    run(0, 17'h00030, 32'h0, 4'hF, 0);  // R8: nothing stored at injected address
    run(0, 17'h00020, 32'h0, 4'hF, 0);
    run(0, 17'h00010, 32'h0, 4'h0, 0);

    // R11: reset inside the write strobe
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 17'h00040; wdata = 32'h01020304; mask = 4'hF;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    check(!we_n, "R11 write strobe active before reset", {31'h0, we_n}, 32'h0);
    rst_ni = 1'b0;
    #1;
    check_idle("R11 strobes released on reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R11 access dropped");
    run(0, 17'h00010, 32'h0, 4'hF, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule